// File: doc/BRIEF.md
# Multiplexed LCD Row-Scan Sequencer

This block paces the scan of a 40-row by 101-column passive-matrix panel driven at a 1:40 multiplex ratio. It runs from the panel oscillator clock. It steps a row index through all rows so that one frame lasts exactly 3072 clocks. Each completed frame flips a polarity flag, so the average voltage across every pixel is zero over two frames.

Once per row period the block asks the display memory for one row of pixel bits. It captures that row at the end of the previous row's dwell. For every row pin and every column pin it produces a three-bit code, and that code selects one of six analog drive levels. The codes depend on the scanned row, the polarity flag, the pixel bit, the display mode and the sleep control. A separate analog stage turns the codes into voltages.

Top module: `lcd_scan_top`

## Requirements
- R1: While reset is asserted, `row_idx` is 0 and `frame_odd` is 0. The captured row data is all zero. With sleep low, row 0 shows code 0 (positive rail), every other row shows code 3 and every column shows code 2.
- R2: Rows are scanned in rising order from 0 to 39 and then wrap to 0. Rows 0 to 31 each last 77 clocks and rows 32 to 39 each last 76 clocks. The first clock after reset only captures row 0's data and does not advance the dwell count.
- R3: A frame lasts 3072 clocks. `frame_odd` toggles exactly when the index wraps from row 39 to row 0.
- R4: The level codes are: 0 positive rail, 1 upper-outer bias, 2 upper-inner bias, 3 lower-inner bias, 4 lower-outer bias, 5 negative rail. Each row field is `row_lvl[3*r+2:3*r]`. The selected row drives 0 in even frames and 5 in odd frames. Unselected rows drive 3 in even frames and 2 in odd frames.
- R5: Each column field is `col_lvl[3*c+2:3*c]`, with column c taken from `row_data[c]`. In even frames a lit pixel drives 5 and a dark pixel drives 2. In odd frames a lit pixel drives 0 and a dark pixel drives 3.
- R6: The mode inputs set whether a pixel is lit. `ctl_show`=0 and `ctl_fill`=0 gives all pixels dark. `ctl_show`=1 and `ctl_fill`=0 shows the stored bit. `ctl_show`=0 and `ctl_fill`=1 gives all pixels lit. `ctl_show`=1 and `ctl_fill`=1 shows the inverted stored bit. A mode change takes effect in the same cycle, with no register in between.
- R7: While `ctl_sleep` is 1, every row and column field is code 0.
- R8: While `ctl_sleep` is 1, the scan position, the polarity and the captured row data hold. When sleep is released, scanning resumes from the same dwell position.
- R9: In the last clock of a dwell, `fetch_row` shows the next row; otherwise it shows the current row. The data on `row_data` is captured at that edge. All outputs move to the new row in the same cycle as `row_idx` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_show | input | 1 | Mode bit: show stored data (see R6) |
| ctl_fill | input | 1 | Mode bit: fill or invert (see R6) |
| ctl_sleep | input | 1 | Sleep: force all outputs to code 0 and hold the scan |
| row_data | input | 101 | Pixel bits of the row at `fetch_row`, one bit per column |
| fetch_row | output | 6 | Row whose data the memory must present |
| row_idx | output | 6 | Row being driven now |
| frame_odd | output | 1 | Polarity of the current frame |
| row_lvl | output | 120 | Level code per row, 3 bits each |
| col_lvl | output | 303 | Level code per column, 3 bits each |

## Verification
On every clock, the assertions check the following:
- a row change happens only after a full dwell of the correct length, and polarity flips only at the wrap;
- the scan stays frozen while sleep is high;
- exactly one row sits at a rail level, and columns never use the outer bias codes;
- sleep forces every pin to code 0;
- captured data changes only at a fetch.

Only the bench scenarios show the exact cycle at which each boundary falls and the exact code of every pin for a known memory pattern. The same goes for the four mode encodings, the resumption point after sleep, and the reset picture.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
    localparam int LVL_W = 3;

    typedef enum logic [LVL_W-1:0] {
        LVL_POS    = 3'd0,
        LVL_BIAS_A = 3'd1,
        LVL_BIAS_B = 3'd2,
        LVL_BIAS_C = 3'd3,
        LVL_BIAS_D = 3'd4,
        LVL_NEG    = 3'd5
    } lvl_e;
endpackage

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer #(
    parameter int ROWS       = 40,
    parameter int FRAME_CLKS = 3072,
    localparam int ROW_W     = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    output logic [ROW_W-1:0] row_idx,
    output logic             frame_odd,
    output logic [ROW_W-1:0] fetch_row,
    output logic             load
);
    localparam int SHORT_DW  = FRAME_CLKS / ROWS;
    localparam int LONG_DW   = SHORT_DW + 1;
    localparam int LONG_ROWS = FRAME_CLKS % ROWS;
    localparam int DW_W      = $clog2(LONG_DW);

    localparam logic [DW_W-1:0]  LONG_M1  = DW_W'(LONG_DW - 1);
    localparam logic [DW_W-1:0]  SHORT_M1 = DW_W'(SHORT_DW - 1);
    localparam logic [ROW_W-1:0] LONG_LIM = ROW_W'(LONG_ROWS);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

    typedef struct packed {
        logic [DW_W-1:0]  dwell;
        logic [ROW_W-1:0] row;
        logic             odd;
        logic             prime;
    } scan_t;

    scan_t            st_d, st_q;
    logic             last;
    logic [DW_W-1:0]  len_m1;
    logic [ROW_W-1:0] next_row;

    always_comb begin
        st_d     = st_q;
        len_m1   = (st_q.row < LONG_LIM) ? LONG_M1 : SHORT_M1;
        last     = (st_q.dwell == len_m1);
        next_row = (st_q.row == LAST_ROW) ? '0 : st_q.row + 1'b1;
        load     = !hold && (st_q.prime || last);
        if (!hold) begin
            if (st_q.prime) begin
                st_d.prime = 1'b0;
            end else if (last) begin
                st_d.dwell = '0;
                st_d.row   = next_row;
                if (st_q.row == LAST_ROW) st_d.odd = ~st_q.odd;
            end else begin
                st_d.dwell = st_q.dwell + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{dwell: '0, row: '0, odd: 1'b0, prime: 1'b1};
        else        st_q <= st_d;
    end

    assign row_idx   = st_q.row;
    assign frame_odd = st_q.odd;
    assign fetch_row = last ? next_row : st_q.row;

    // R2
    row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.row < ROW_W'(ROWS));
    // R2
    dwell_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.row != $past(st_q.row)) |->
            ($past(st_q.dwell) == (($past(st_q.row) < LONG_LIM) ? LONG_M1 : SHORT_M1)));
    // R3
    frame_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.odd != $past(st_q.odd)) |-> ($past(st_q.row) == LAST_ROW && st_q.row == '0));
    // R8
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(st_q.row) && $stable(st_q.dwell) && $stable(st_q.odd)));
endmodule

// File: rtl/lcd_scan_latch.sv
module lcd_scan_latch #(
    parameter int COLS = 101
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [COLS-1:0] din,
    output logic [COLS-1:0] pix
);
    typedef struct packed {
        logic [COLS-1:0] bits;
    } pix_t;

    pix_t pix_d, pix_q;

    always_comb begin
        pix_d = pix_q;
        if (load) pix_d.bits = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pix_q <= '0;
        else        pix_q <= pix_d;
    end

    assign pix = pix_q.bits;
endmodule

// File: rtl/lcd_scan_levels.sv
module lcd_scan_levels
    import lcd_scan_pkg::*;
#(
    parameter int ROWS = 40,
    parameter int COLS = 101,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ROW_W-1:0]      row_idx,
    input  logic                  odd,
    input  logic [COLS-1:0]       pix,
    input  logic                  show,
    input  logic                  fill,
    input  logic                  sleep,
    output logic [ROWS*LVL_W-1:0] row_lvl,
    output logic [COLS*LVL_W-1:0] col_lvl
);
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        lvl_e code;
        always_comb begin
            if (sleep)                        code = LVL_POS;
            else if (row_idx == ROW_W'(r))    code = odd ? LVL_NEG : LVL_POS;
            else                              code = odd ? LVL_BIAS_B : LVL_BIAS_C;
        end
        assign row_lvl[r*LVL_W +: LVL_W] = code;
    end

    for (genvar c = 0; c < COLS; c++) begin : g_col
        lvl_e code;
        logic lit;
        assign lit = show ? (pix[c] ^ fill) : fill;
        always_comb begin
            if (sleep)     code = LVL_POS;
            else if (odd)  code = lit ? LVL_POS : LVL_BIAS_C;
            else           code = lit ? LVL_NEG : LVL_BIAS_B;
        end
        assign col_lvl[c*LVL_W +: LVL_W] = code;
    end

    int rail_rows;
    logic col_outer;
    always_comb begin
        rail_rows = 0;
        for (int r = 0; r < ROWS; r++)
            if (row_lvl[r*LVL_W +: LVL_W] == LVL_POS || row_lvl[r*LVL_W +: LVL_W] == LVL_NEG)
                rail_rows = rail_rows + 1;
        col_outer = 1'b0;
        for (int c = 0; c < COLS; c++)
            if (col_lvl[c*LVL_W +: LVL_W] == LVL_BIAS_A || col_lvl[c*LVL_W +: LVL_W] == LVL_BIAS_D)
                col_outer = 1'b1;
    end

    // R4
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep |-> rail_rows == 1);
    // R5
    col_inner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !col_outer);
    // R7
    sleep_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (row_lvl == '0 && col_lvl == '0));
endmodule

// File: rtl/lcd_scan_top.sv
module lcd_scan_top
    import lcd_scan_pkg::*;
#(
    parameter int ROWS       = 40,
    parameter int COLS       = 101,
    parameter int FRAME_CLKS = 3072,
    localparam int ROW_W     = $clog2(ROWS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctl_show,
    input  logic                  ctl_fill,
    input  logic                  ctl_sleep,
    input  logic [COLS-1:0]       row_data,
    output logic [ROW_W-1:0]      fetch_row,
    output logic [ROW_W-1:0]      row_idx,
    output logic                  frame_odd,
    output logic [ROWS*LVL_W-1:0] row_lvl,
    output logic [COLS*LVL_W-1:0] col_lvl
);
    logic            load;
    logic [COLS-1:0] pix;

    lcd_scan_timer #(.ROWS(ROWS), .FRAME_CLKS(FRAME_CLKS)) i_timer (
        .clk(clk), .rst_n(rst_n), .hold(ctl_sleep),
        .row_idx(row_idx), .frame_odd(frame_odd),
        .fetch_row(fetch_row), .load(load)
    );

    lcd_scan_latch #(.COLS(COLS)) i_latch (
        .clk(clk), .rst_n(rst_n), .load(load), .din(row_data), .pix(pix)
    );

    lcd_scan_levels #(.ROWS(ROWS), .COLS(COLS)) i_levels (
        .clk(clk), .rst_n(rst_n), .row_idx(row_idx), .odd(frame_odd),
        .pix(pix), .show(ctl_show), .fill(ctl_fill), .sleep(ctl_sleep),
        .row_lvl(row_lvl), .col_lvl(col_lvl)
    );

    // R9
    pix_at_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix != $past(pix)) |-> $past(load));
endmodule

// File: tb/test_lcd_scan_top.sv
`timescale 1ns/1ps
module test_lcd_scan_top;
    localparam int ROWS = 40;
    localparam int COLS = 101;
    localparam int FR   = 3072;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ctl_show = 1'b1, ctl_fill = 1'b0, ctl_sleep = 1'b0;
    logic [COLS-1:0] row_data;
    logic [5:0]      fetch_row, row_idx;
    logic            frame_odd;
    logic [ROWS*3-1:0] row_lvl;
    logic [COLS*3-1:0] col_lvl;

    int checks = 0;
    int errors = 0;
    int k = 0;

    always #4 clk = ~clk;

    lcd_scan_top i_lcd_scan_top (
        .clk(clk), .rst_n(rst_n), .ctl_show(ctl_show), .ctl_fill(ctl_fill),
        .ctl_sleep(ctl_sleep), .row_data(row_data), .fetch_row(fetch_row),
        .row_idx(row_idx), .frame_odd(frame_odd), .row_lvl(row_lvl), .col_lvl(col_lvl)
    );

    function automatic logic pat(int r, int c);
        return ((r * 5 + c * 3) % 7) < 3;
    endfunction

    always_comb
        for (int c = 0; c < COLS; c++) row_data[c] = pat(int'(fetch_row), c);

    always @(posedge clk) if (rst_n && !ctl_sleep) k <= k + 1;

    function automatic int pos_row(int s);
        s = s % FR;
        if (s < 32 * 77) return s / 77;
        return 32 + (s - 32 * 77) / 76;
    endfunction

    function automatic bit pos_last(int s);
        s = s % FR;
        if (s < 32 * 77) return (s % 77) == 76;
        return ((s - 32 * 77) % 76) == 75;
    endfunction

    task automatic fail(string req, string what, int act, int exp);
        errors++;
        $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    endtask

    task automatic check_now(string req);
        int s = k - 1;
        int er = pos_row(s);
        int eo = (s / FR) % 2;
        int ef = pos_last(s) ? (er + 1) % ROWS : er;
        int bad_row = -1, bad_col = -1, ea = 0, aa = 0;
        checks++;
        if (row_idx !== 6'(er)) fail(req, "row_idx", int'(row_idx), er);
        else if (frame_odd !== eo[0]) fail(req, "frame_odd", int'(frame_odd), eo);
        else if (fetch_row !== 6'(ef)) fail(req, "fetch_row", int'(fetch_row), ef);
        checks++;
        for (int r = 0; r < ROWS; r++) begin
            int e;
            if (ctl_sleep) e = 0;
            else if (r == er) e = eo ? 5 : 0;
            else e = eo ? 2 : 3;
            if (bad_row < 0 && int'(row_lvl[r*3 +: 3]) != e) begin
                bad_row = r; aa = int'(row_lvl[r*3 +: 3]); ea = e;
            end
        end
        if (bad_row >= 0) fail(req, $sformatf("row %0d level", bad_row), aa, ea);
        checks++;
        for (int c = 0; c < COLS; c++) begin
            int e;
            logic lit = ctl_show ? (pat(er, c) ^ ctl_fill) : ctl_fill;
            if (ctl_sleep) e = 0;
            else if (eo) e = lit ? 0 : 3;
            else e = lit ? 5 : 2;
            if (bad_col < 0 && int'(col_lvl[c*3 +: 3]) != e) begin
                bad_col = c; aa = int'(col_lvl[c*3 +: 3]); ea = e;
            end
        end
        if (bad_col >= 0) fail(req, $sformatf("col %0d level", bad_col), aa, ea);
    endtask

    task automatic run_checked(int n, string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_now(req);
        end
    endtask

    // R1: reset picture
    task automatic t_reset();
        @(negedge clk);
        checks++;
        if (row_idx !== 6'd0 || frame_odd !== 1'b0)
            fail("R1", "row_idx/frame_odd", int'({row_idx, frame_odd}), 0);
        checks++;
        if (row_lvl[2:0] !== 3'd0) fail("R1", "row 0 level", int'(row_lvl[2:0]), 0);
        checks++;
        if (row_lvl[5:3] !== 3'd3) fail("R1", "row 1 level", int'(row_lvl[5:3]), 3);
        checks++;
        if (col_lvl[2:0] !== 3'd2 || col_lvl[COLS*3-1 -: 3] !== 3'd2)
            fail("R1", "column level", int'(col_lvl[2:0]), 2);
        rst_n = 1'b1;
    endtask

    // R2 R3 R4 R5 R9: two full frames plus wrap, every cycle
    task automatic t_scan();
        int changes = 0;
        logic [5:0] prev;
        @(negedge clk);
        check_now("R2");
        prev = row_idx;
        for (int i = 0; i < 2 * FR + 200; i++) begin
            @(negedge clk);
            check_now(i < FR ? "R4" : "R5");
            if (row_idx != prev) changes++;
            prev = row_idx;
        end
        checks++;
        if (changes != 2 * ROWS + 2) fail("R3", "row changes", changes, 2 * ROWS + 2);
        run_checked(5, "R9");
    endtask

    // R6: the four display modes
    task automatic t_modes();
        for (int m = 0; m < 4; m++) begin
            @(negedge clk);
            ctl_show = m[0];
            ctl_fill = m[1];
            run_checked(120, "R6");
        end
        @(negedge clk);
        ctl_show = 1'b1;
        ctl_fill = 1'b0;
    endtask

    // R7 R8: sleep forces rails and freezes the scan
    task automatic t_sleep();
        logic [5:0] r0;
        logic o0;
        @(negedge clk);
        ctl_sleep = 1'b1;
        r0 = row_idx;
        o0 = frame_odd;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            check_now("R7");
            checks++;
            if (row_idx !== r0 || frame_odd !== o0) fail("R8", "frozen row", int'(row_idx), int'(r0));
        end
        ctl_sleep = 1'b0;
        run_checked(400, "R8");
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_scan();
        t_modes();
        t_sleep();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule